// File: doc/BRIEF.md
# Bayer Defective Pixel Corrector

The block takes in a small raw mosaic image one pixel at a time, finds pixels whose value stands far outside the range of their same-colour neighbours, and replaces each of them with a median of those neighbours. It then streams the repaired image back out. Pixels enter while the load strobe `mod_en` is high. After the last pixel has arrived, the block works without further input. When it finishes, it sends out the whole image, one pixel per cycle, with a single-cycle valid flag on each pixel.

Internally the image is placed in a working buffer that is four pixels larger in each dimension. This buffer has a two-pixel frame of value 127 all around the image, so corners and edges use the same neighbour rule as the interior. Finding the bad pixels and repairing them are two separate passes. Every pixel is classified first, from the original values. Only then does repair begin, and any neighbour that is itself marked bad enters the median as 127 instead of its own value.

The controller steps through these states:

- `S_IDLE` goes to `S_LOAD` on the first strobe.
- `S_LOAD` goes to `S_PAD` on the last pixel.
- `S_PAD`, `S_MAP`, `S_DETECT` and `S_SCAN` follow in turn, each ending on its last index.
- `S_SCAN` goes to `S_FEED` when the map bit of the current pixel is set, and to `S_DEMAP` after the last pixel.
- `S_FEED` goes to `S_WAIT` after nine values.
- `S_WAIT` goes back to `S_SCAN`, or to `S_DEMAP` if the pixel was the last one, when the median is ready.
- `S_DEMAP` goes to `S_EMIT`, and `S_EMIT` returns to `S_IDLE` after the last output pixel.

Top module: `dpc_core`

## Requirements
- R1: While reset is active and on the first cycle after it, `out_valid` is 0 and `pix_out` is 0. A partly loaded image is discarded by reset, and the next strobe starts a new image at pixel 0.
- R2: In `S_IDLE` and `S_LOAD`, every cycle with `mod_en` high stores `pix_in` at the next raster position, index row*IMG_W+col. Cycles with `mod_en` low pause the load. `out_valid` stays 0 while loading.
- R3: Any neighbour position outside the image reads as 127, both for detection and as a median input.
- R4: A pixel is marked defective when it is greater than THRESH plus the largest of its eight neighbours, or when it plus THRESH is less than the smallest of them. Both comparisons use one extra bit, so a sum above the pixel range does not wrap and a difference below zero does not wrap.
- R5: Every pixel is classified before any replacement. Classification uses only original values.
- R6: The eight neighbours of a pixel sit at row and column offsets of -2, 0 and +2, leaving out the centre. A defective pixel is replaced by the fifth smallest of nine values: those eight neighbours and one fixed 127.
- R7: A neighbour that is itself marked defective enters the median as 127.
- R8: Pixels that are not marked defective leave the block unchanged.
- R9: The output is IMG_W*IMG_H pixels in raster order, on consecutive cycles, with `out_valid` high for exactly one cycle per pixel.
- R10: `mod_en` and `pix_in` have no effect from the end of the load until after the last output pixel.
- R11: After the last output pixel the block is back in `S_IDLE`, and a following strobe loads a new image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_en | input | 1 | Load strobe; one pixel is taken per high cycle |
| pix_in | input | PIX_W | Incoming raw pixel |
| out_valid | output | 1 | High for one cycle per output pixel |
| pix_out | output | PIX_W | Corrected output pixel |

## Verification
A pixel is stored at the clock edge that ends its strobe cycle. The latency from the last stored pixel to the first output depends on how many pixels are defective and on how long each median sort takes, so the bench does not predict that count. Instead it waits for the first valid cycle and then expects a valid, correctly valued pixel on each of the next IMG_W*IMG_H cycles, followed by a low flag on the cycle after. All inputs change and all outputs are sampled on the falling clock edge, half a period away from the register updates, so each expected pixel is compared in the cycle its register presents it.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_PAD,
        S_MAP,
        S_DETECT,
        S_SCAN,
        S_FEED,
        S_WAIT,
        S_DEMAP,
        S_EMIT
    } state_t;

    // eight same-colour neighbours, one fixed fill value fed to the median
    localparam int NB_CNT = 8;
    localparam int NB_W   = $clog2(NB_CNT);
    localparam int MED_N  = NB_CNT + 1;

    function automatic int nb_drow(input int n);
        case (n)
            0, 1, 2: return -2;
            3, 4:    return 0;
            default: return 2;
        endcase
    endfunction

    function automatic int nb_dcol(input int n);
        case (n)
            0, 3, 5: return -2;
            1, 6:    return 0;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/dpc_classify.sv
module dpc_classify
    import dpc_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int THRESH = 30
) (
    input  logic [PIX_W-1:0]               center,
    input  logic [NB_CNT-1:0][PIX_W-1:0]   nbrs,
    output logic                           defect
);

    localparam logic [PIX_W:0] TH_X = (PIX_W+1)'(THRESH);

    logic [PIX_W-1:0] hi_v, lo_v;
    logic [PIX_W:0]   upper, center_up;

    always_comb begin
        hi_v = nbrs[0];
        lo_v = nbrs[0];
        for (int n = 1; n < NB_CNT; n++) begin
            if (nbrs[n] > hi_v) hi_v = nbrs[n];
            if (nbrs[n] < lo_v) lo_v = nbrs[n];
        end
        // one extra bit: the sum never wraps, and the low test is rearranged to avoid a subtraction
        upper     = {1'b0, hi_v} + TH_X;
        center_up = {1'b0, center} + TH_X;
        defect    = ({1'b0, center} > upper) || (center_up < {1'b0, lo_v});
    end

endmodule

// File: rtl/dpc_median.sv
module dpc_median #(
    parameter int PIX_W = 8,
    parameter int N     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PIX_W-1:0] din,
    output logic             done,
    output logic [PIX_W-1:0] med
);

    localparam int JW = $clog2(N);

    logic [PIX_W-1:0] vals [N];
    logic [JW-1:0]    cnt;
    logic [JW-1:0]    cnt_nx1;
    logic             sorting;
    logic             swp;
    logic             gt;

    assign cnt_nx1 = cnt + 1'b1;
    assign gt      = sorting && (vals[cnt] > vals[cnt_nx1]);

    // value storage: serial fill, then one compare-exchange per cycle
    always_ff @(posedge clk) begin
        if (!sorting && en) begin
            vals[cnt] <= din;
        end else if (gt) begin
            vals[cnt]     <= vals[cnt_nx1];
            vals[cnt_nx1] <= vals[cnt];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            sorting <= 1'b0;
            swp     <= 1'b0;
            done    <= 1'b0;
            med     <= '0;
        end else begin
            done <= 1'b0;
            if (!sorting) begin
                if (en) begin
                    if (cnt == JW'(N - 1)) begin
                        cnt     <= '0;
                        sorting <= 1'b1;
                        swp     <= 1'b0;
                    end else begin
                        cnt <= cnt_nx1;
                    end
                end
            end else begin
                if (gt) swp <= 1'b1;
                if (cnt == JW'(N - 2)) begin
                    cnt <= '0;
                    if (!swp && !gt) begin
                        // a full pass without exchange: the list is ordered
                        sorting <= 1'b0;
                        done    <= 1'b1;
                        med     <= vals[N/2];
                    end else begin
                        swp <= 1'b0;
                    end
                end else begin
                    cnt <= cnt_nx1;
                end
            end
        end
    end

endmodule

// File: rtl/dpc_core.sv
module dpc_core
    import dpc_pkg::*;
#(
    parameter int IMG_W    = 8,
    parameter int IMG_H    = 8,
    parameter int PIX_W    = 8,
    parameter int THRESH   = 30,
    parameter int FILL_VAL = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic [PIX_W-1:0] pix_in,
    output logic             out_valid,
    output logic [PIX_W-1:0] pix_out
);

    localparam int NPIX  = IMG_W * IMG_H;
    localparam int PAD_W = IMG_W + 4;
    localparam int PAD_H = IMG_H + 4;
    localparam int PAD_N = PAD_W * PAD_H;
    localparam int IW    = $clog2(PAD_N);
    localparam int NIW   = $clog2(NPIX);
    localparam int KW    = $clog2(MED_N);
    localparam logic [PIX_W-1:0] FILL = PIX_W'(FILL_VAL);

    state_t state, state_nx;

    logic [PIX_W-1:0] img [NPIX];
    logic [PIX_W-1:0] pad [PAD_N];
    logic [NPIX-1:0]  dmap;

    logic [IW-1:0]    idx;
    logic [NIW-1:0]   nidx;
    logic [KW-1:0]    k;
    logic             at_last;
    logic [IW-1:0]    ctr;
    int               row, col;

    logic [NB_CNT-1:0][PIX_W-1:0] nb_pack;
    logic [NB_CNT-1:0]            nb_flag;
    logic                         is_def;
    logic                         med_en;
    logic [PIX_W-1:0]             med_din;
    logic                         med_done;
    logic [PIX_W-1:0]             med_q;
    logic [NB_W-1:0]              ksel;

    assign nidx    = idx[NIW-1:0];
    assign at_last = (state == S_PAD) ? (idx == IW'(PAD_N - 1)) : (idx == IW'(NPIX - 1));

    // centre and neighbour positions in the framed buffer
    always_comb begin
        row = int'(nidx) / IMG_W;
        col = int'(nidx) % IMG_W;
        ctr = IW'((row + 2) * PAD_W + col + 2);
        for (int n = 0; n < NB_CNT; n++) begin
            automatic int nr = row + nb_drow(n);
            automatic int nc = col + nb_dcol(n);
            nb_pack[n] = pad[IW'((nr + 2) * PAD_W + nc + 2)];
            nb_flag[n] = 1'b0;
            if (nr >= 0 && nr < IMG_H && nc >= 0 && nc < IMG_W)
                nb_flag[n] = dmap[NIW'(nr * IMG_W + nc)];
        end
    end

    dpc_classify #(
        .PIX_W  (PIX_W),
        .THRESH (THRESH)
    ) u_cls (
        .center (pad[ctr]),
        .nbrs   (nb_pack),
        .defect (is_def)
    );

    assign ksel    = k[NB_W-1:0];
    assign med_en  = (state == S_FEED);
    assign med_din = (k >= KW'(NB_CNT) || nb_flag[ksel]) ? FILL : nb_pack[ksel];

    dpc_median #(
        .PIX_W (PIX_W),
        .N     (MED_N)
    ) u_med (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (med_en),
        .din   (med_din),
        .done  (med_done),
        .med   (med_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (mod_en)            state_nx = S_LOAD;
            S_LOAD:   if (mod_en && at_last) state_nx = S_PAD;
            S_PAD:    if (at_last)           state_nx = S_MAP;
            S_MAP:    if (at_last)           state_nx = S_DETECT;
            S_DETECT: if (at_last)           state_nx = S_SCAN;
            S_SCAN: begin
                if (dmap[nidx])   state_nx = S_FEED;
                else if (at_last) state_nx = S_DEMAP;
            end
            S_FEED:   if (k == KW'(MED_N - 1)) state_nx = S_WAIT;
            S_WAIT:   if (med_done) state_nx = at_last ? S_DEMAP : S_SCAN;
            S_DEMAP:  if (at_last)           state_nx = S_EMIT;
            S_EMIT:   if (at_last)           state_nx = S_IDLE;
            default:                         state_nx = S_IDLE;
        endcase
    end

    // index, feed counter and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            k         <= '0;
            out_valid <= 1'b0;
            pix_out   <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                S_IDLE, S_LOAD: begin
                    if (mod_en) idx <= at_last ? '0 : idx + 1'b1;
                end
                S_PAD, S_MAP, S_DETECT, S_DEMAP: begin
                    idx <= at_last ? '0 : idx + 1'b1;
                end
                S_SCAN: begin
                    k <= '0;
                    if (!dmap[nidx]) idx <= at_last ? '0 : idx + 1'b1;
                end
                S_FEED: begin
                    k <= k + 1'b1;
                end
                S_WAIT: begin
                    if (med_done) idx <= at_last ? '0 : idx + 1'b1;
                end
                S_EMIT: begin
                    out_valid <= 1'b1;
                    pix_out   <= img[nidx];
                    idx       <= at_last ? '0 : idx + 1'b1;
                end
                default: idx <= '0;
            endcase
        end
    end

    // image, framed buffer and defect map
    always_ff @(posedge clk) begin
        if ((state == S_IDLE || state == S_LOAD) && mod_en) img[nidx] <= pix_in;
        if (state == S_PAD)                   pad[idx]   <= FILL;
        if (state == S_MAP)                   pad[ctr]   <= img[nidx];
        if (state == S_DETECT)                dmap[nidx] <= is_def;
        if (state == S_WAIT && med_done)      pad[ctr]   <= med_q;
        if (state == S_DEMAP)                 img[nidx]  <= pad[ctr];
    end

endmodule

// File: rtl/dpc_core_chk.sv
module dpc_core_chk
    import dpc_pkg::*;
#(
    parameter int NPIX = 64
) (
    input logic   clk,
    input logic   rst_n,
    input state_t state,
    input logic   out_valid,
    input logic   med_done
);

    logic [15:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run <= '0;
        else if (out_valid) run <= run + 1'b1;
        else                run <= '0;
    end

    // R9: each output burst is exactly one image long
    a_r9_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> run == 16'(NPIX));

    // R9: a valid pixel only follows an emit cycle
    a_r9_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state) == S_EMIT);

    // R6: the median result is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        med_done |=> !med_done);

    // R6: a median result arrives only while the controller waits for it
    a_r6_done_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        med_done |-> state == S_WAIT);

    // R11: leaving the output phase always lands in idle
    a_r11_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_EMIT && state != S_EMIT) |-> state == S_IDLE);

endmodule

bind dpc_core dpc_core_chk #(.NPIX(IMG_W * IMG_H)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .out_valid (out_valid),
    .med_done  (med_done)
);

// File: tb/dpc_core_test.sv
`timescale 1ns/1ps
module dpc_core_test;

    localparam int W    = 8;
    localparam int H    = 8;
    localparam int NPIX = W * H;
    localparam int THR  = 30;
    localparam int FILL = 127;

    // fields: pattern, r0, c0, v0, r1, c1, v1, use1, gaps, junk, keep0 (1 = pixel 0 must stay), tag
    localparam int NSCN = 7;
    localparam int SCN [NSCN][12] = '{
        '{0, 4, 4, 250, 0, 0,   0, 0, 1, 0, 0, 5},
        '{0, 3, 3, 250, 3, 5,   5, 1, 0, 0, 0, 7},
        '{0, 0, 0, 255, 7, 7,   0, 1, 1, 0, 0, 3},
        '{1, 4, 4, 255, 0, 0,   0, 0, 0, 0, 1, 4},
        '{2, 4, 4,   0, 0, 0,   0, 0, 0, 0, 1, 4},
        '{3, 1, 6,   0, 6, 1, 255, 1, 0, 1, 0, 10},
        '{0, 2, 2,  94, 0, 0,   0, 0, 0, 0, 1, 8}
    };
    localparam int DR [8] = '{-2, -2, -2, 0, 0, 2, 2, 2};
    localparam int DC [8] = '{-2, 0, 2, -2, 2, -2, 0, 2};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mod_en;
    logic [7:0] pix_in;
    logic       out_valid;
    logic [7:0] pix_out;

    int checks = 0;
    int errors = 0;
    int im [H][W];
    int pd [H+4][W+4];
    bit fl [H][W];
    int ex [NPIX];
    string ptag [NPIX];

    always #2 clk = ~clk;

    dpc_core #(.IMG_W(W), .IMG_H(H), .PIX_W(8), .THRESH(THR), .FILL_VAL(FILL)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_en    (mod_en),
        .pix_in    (pix_in),
        .out_valid (out_valid),
        .pix_out   (pix_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_name(input int t);
        case (t)
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            7:       return "R7";
            8:       return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic int pat_val(input int p, input int r, input int c);
        case (p)
            0: begin
                case ({r[0], c[0]})
                    2'b00:   return 90 + (r * c) % 5;
                    2'b01:   return 140 + (r * c) % 5;
                    2'b10:   return 60 + (r * c) % 5;
                    default: return 110 + (r * c) % 5;
                endcase
            end
            1:       return 240;
            2:       return 10;
            default: return 20 + r * 25 + c * 3;
        endcase
    endfunction

    // independent model: frame, classify everything, then repair
    task automatic build_model();
        for (int r = 0; r < H + 4; r++)
            for (int c = 0; c < W + 4; c++) pd[r][c] = FILL;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) pd[r+2][c+2] = im[r][c];
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                automatic int mx = -1;
                automatic int mn = 100000;
                for (int n = 0; n < 8; n++) begin
                    automatic int v = pd[r+2+DR[n]][c+2+DC[n]];
                    if (v > mx) mx = v;
                    if (v < mn) mn = v;
                end
                fl[r][c] = (im[r][c] > mx + THR) || (im[r][c] < mn - THR);
            end
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                if (!fl[r][c]) begin
                    ex[r*W+c]   = im[r][c];
                    ptag[r*W+c] = "R8";
                end else begin
                    automatic int lst [9];
                    automatic bit sub = 0;
                    for (int n = 0; n < 8; n++) begin
                        automatic int rr = r + DR[n];
                        automatic int cc = c + DC[n];
                        if (rr >= 0 && rr < H && cc >= 0 && cc < W && fl[rr][cc]) begin
                            lst[n] = FILL;
                            sub = 1;
                        end else begin
                            lst[n] = pd[rr+2][cc+2];
                        end
                    end
                    lst[8] = FILL;
                    for (int a = 1; a < 9; a++)
                        for (int b = a; b > 0 && lst[b-1] > lst[b]; b--) begin
                            automatic int t = lst[b];
                            lst[b] = lst[b-1];
                            lst[b-1] = t;
                        end
                    ex[r*W+c]   = lst[4];
                    ptag[r*W+c] = sub ? "R7" : "R6";
                end
            end
    endtask

    task automatic run_image(input bit gaps, input bit junk);
        automatic int t = 0;
        for (int i = 0; i < NPIX; i++) begin
            if (gaps && (i % 5 == 2)) begin
                mod_en = 1'b0;
                @(negedge clk);
            end
            mod_en = 1'b1;
            pix_in = 8'(im[i/W][i%W]);
            @(negedge clk);
        end
        mod_en = 1'b0;
        check(out_valid == 1'b0, "R2 valid low after load", int'(out_valid), 0);
        while (!out_valid && t < 20000) begin
            if (junk) begin
                mod_en = (t % 3 == 0);
                pix_in = 8'(t * 7);
            end
            @(negedge clk);
            t++;
        end
        mod_en = 1'b0;
        check(out_valid == 1'b1, "R9 output burst started", int'(out_valid), 1);
        for (int i = 0; i < NPIX; i++) begin
            check(out_valid && (int'(pix_out) == ex[i]), ptag[i], int'(pix_out), ex[i]);
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R9 burst ends after one image", int'(out_valid), 0);
    endtask

    task automatic setup_scn(input int s);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) im[r][c] = pat_val(SCN[s][0], r, c);
        im[SCN[s][1]][SCN[s][2]] = SCN[s][3];
        if (SCN[s][7] != 0) im[SCN[s][4]][SCN[s][5]] = SCN[s][6];
        build_model();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        mod_en = 1'b0;
        pix_in = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(pix_out == 8'd0, "R1 pixel in reset", int'(pix_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(pix_out == 8'd0, "R1 pixel after reset", int'(pix_out), 0);

        // table walk: each vector gives an image, its defects and a hand-derived expectation
        for (int s = 0; s < NSCN; s++) begin
            automatic int p0;
            setup_scn(s);
            p0 = SCN[s][1] * W + SCN[s][2];
            if (SCN[s][10] != 0)
                check(ex[p0] == SCN[s][3], tag_name(SCN[s][11]), ex[p0], SCN[s][3]);
            else
                check(ex[p0] != SCN[s][3], tag_name(SCN[s][11]), ex[p0], SCN[s][3]);
            run_image(SCN[s][8] != 0, SCN[s][9] != 0);
        end

        // R11: idle after a burst, nothing emitted without a new load
        repeat (10) @(negedge clk);
        check(out_valid == 1'b0, "R11 idle stays quiet", int'(out_valid), 0);

        // R1: reset in the middle of a load drops the partial image
        for (int i = 0; i < 20; i++) begin
            mod_en = 1'b1;
            pix_in = 8'd200;
            @(negedge clk);
        end
        mod_en = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in mid-load reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        setup_scn(0);
        run_image(1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule